// File: doc/BRIEF.md
# Burst PSRAM Host Controller

This block connects an on-chip request port to a 16-bit pseudo-static RAM that transfers data in synchronous bursts. A host hands over one request at a time through a valid/ready handshake. The request carries a start address, a read or write flag, a beat count and a byte mask. The controller then runs the memory bus through a one-cycle address phase, a programmable initial latency and a data phase. In the data phase it moves one 16-bit beat per clock. It stalls on any clock where the memory's WAIT output reports that data is not ready, for example while an internal refresh collides with the access.

A request flagged as a configuration access becomes a single-cycle write with the configuration-enable pin raised. The configuration word travels on the address pins. When the word selects the bus configuration register, the controller keeps a shadow copy of three fields: latency, WAIT polarity and burst length. This keeps its own sequencing in step with the memory. The memory clock is the controller clock, gated by `mem_clk_en`. The data bus is split into separate in and out vectors with a drive enable, which the pad ring combines.

Top module: `psram_burst_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the controller holds the following values. `req_ready` is high. `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lat_n`, `mem_ub_n` and `mem_lb_n` are high. `mem_cre`, `mem_dq_oe` and `mem_clk_en` are low.
- R2: A request accepted on a clock edge starts the address phase in the next cycle. In that cycle `mem_ce_n` is low, `mem_lat_n` is low, `mem_addr` equals the request address and `mem_we_n` is low only for writes. `mem_lat_n` is low for exactly that one cycle. Through the whole access, `mem_ub_n` is the inverse of mask bit 1 and `mem_lb_n` is the inverse of mask bit 0.
- R3: The first data beat falls L+1 cycles after the address cycle. L is the latency field, bits [13:11] of the bus configuration word. With L = 0, data starts in the cycle right after the address cycle.
- R4: A beat transfers only in a data-phase cycle where WAIT is inactive. Every cycle with WAIT active stretches the access by one cycle without losing a beat. Bit 10 of the bus configuration word sets WAIT polarity: 1 means active high and 0 means active low.
- R5: For reads, `mem_oe_n` is low in exactly the data-phase cycles. `rd_valid` pulses once per beat, and `rd_data` carries the value on `mem_dq_in` in that cycle.
- R6: For writes, `mem_dq_oe` is high in exactly the data-phase cycles. `mem_dq_out` carries `wr_data`, and `wr_ready` pulses once per beat. `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: A write transfers `req_beats` beats, and a count of 0 is treated as 1. A read is capped by the burst-length field, bits [2:0] of the bus configuration word: code 1 caps it at 4 beats, code 2 at 8 and code 3 at 16. Any other code means continuous, and then `req_beats` is used.
- R8: `mem_ce_n` rises in the cycle right after the last beat. It never rises in the cycle following a data-phase cycle with WAIT active.
- R9: A configuration request produces one cycle with `mem_cre` high, `mem_we_n` low, `mem_lat_n` low and `mem_ce_n` low. In that cycle `mem_addr` holds the word and both byte enables are high. Only a word with bits [19:18] = 2'b10 updates the latency, polarity and length the controller uses. Any other select leaves them unchanged.
- R10: After reset the controller uses latency 3, active-low WAIT and continuous burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also gated out as the memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = burst write, 0 = burst read |
| req_cfg | input | 1 | 1 = configuration-register write of req_addr |
| req_addr | input | 22 | Start address, or configuration word |
| req_beats | input | 5 | Requested beat count |
| req_bmask | input | 2 | Byte mask, bit 1 upper byte, bit 0 lower byte |
| wr_data | input | 16 | Write data for the current beat |
| wr_ready | output | 1 | Write beat taken this cycle |
| rd_data | output | 16 | Read data for the current beat |
| rd_valid | output | 1 | Read beat delivered this cycle |
| mem_clk_en | output | 1 | Enable for the gated memory clock |
| mem_addr | output | 22 | Memory address pins |
| mem_lat_n | output | 1 | Address latch strobe, active low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_cre | output | 1 | Configuration-register enable |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data sampled from the memory |
| mem_wait | input | 1 | Memory data-valid WAIT, polarity programmable |

## Verification
The bench builds the controller with its default parameters: 22 address bits, 16 data bits and a 5-bit beat count. A 5-bit count lets a read of 20 beats meet the 16-beat cap and a zero count reach the one-beat floor. The bench programs every latency from 0 to 5, both WAIT polarities and all three fixed lengths plus continuous. It inserts WAIT stalls mid-burst for reads and writes. It also checks that a refresh-register write leaves the active settings untouched.

// File: rtl/psram_pkg.sv
package psram_pkg;
    localparam int LAT_W  = 3;
    localparam int BLEN_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_LAT  = 2'd2,
        ST_DATA = 2'd3
    } phase_e;

    typedef struct packed {
        logic [LAT_W-1:0]  lat;
        logic              wait_hi;
        logic [BLEN_W-1:0] blen;
    } bus_cfg_t;

    localparam bus_cfg_t BUS_CFG_RST = '{lat: 3'd3, wait_hi: 1'b0, blen: 3'd7};
endpackage

// File: rtl/psram_cfg_shadow.sv
module psram_cfg_shadow
    import psram_pkg::*;
#(
    parameter logic [1:0] SEL_BUS = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        sel,
    input  logic [LAT_W-1:0]  lat,
    input  logic              wait_hi,
    input  logic [BLEN_W-1:0] blen,
    output bus_cfg_t          cfg
);
    bus_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load && sel == SEL_BUS) begin
            cfg_d.lat     = lat;
            cfg_d.wait_hi = wait_hi;
            cfg_d.blen    = blen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= BUS_CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/psram_len_sel.sv
module psram_len_sel
    import psram_pkg::*;
#(
    parameter int BEAT_W = 5
) (
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              is_read,
    input  logic [BLEN_W-1:0] blen,
    output logic [BEAT_W-1:0] eff_beats
);
    logic [BEAT_W-1:0] base;
    logic [BEAT_W-1:0] cap;

    always_comb begin
        base = (req_beats == '0) ? BEAT_W'(1) : req_beats;
        unique case (blen)
            3'd1:    cap = BEAT_W'(4);
            3'd2:    cap = BEAT_W'(8);
            3'd3:    cap = BEAT_W'(16);
            default: cap = '0;
        endcase
        eff_beats = (is_read && cap != '0 && base > cap) ? cap : base;
    end
endmodule

// File: rtl/psram_wait_norm.sv
module psram_wait_norm (
    input  logic mem_wait,
    input  logic wait_hi,
    output logic wait_act
);
    assign wait_act = wait_hi ? mem_wait : ~mem_wait;
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int BEAT_W   = 5,
    parameter int SEL_LSB  = 18,
    parameter int LAT_LSB  = 11,
    parameter int POL_BIT  = 10,
    parameter int BLEN_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_cfg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [1:0]        req_bmask,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_clk_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_lat_n,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic              mem_cre,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              mem_wait
);
    typedef struct packed {
        phase_e            st;
        logic [BEAT_W-1:0] cnt;
        logic [LAT_W-1:0]  lat;
        logic              wr;
        logic              cfg;
        logic [1:0]        be;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    localparam regs_t REGS_RST = '{st: ST_IDLE, default: '0};

    regs_t             q, d;
    bus_cfg_t          bcfg;
    logic              wait_act;
    logic              take;
    logic              beat;
    logic [BEAT_W-1:0] eff_beats;

    assign take = req_valid && (q.st == ST_IDLE);

    psram_cfg_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take && req_cfg),
        .sel     (req_addr[SEL_LSB +: 2]),
        .lat     (req_addr[LAT_LSB +: LAT_W]),
        .wait_hi (req_addr[POL_BIT]),
        .blen    (req_addr[BLEN_LSB +: BLEN_W]),
        .cfg     (bcfg)
    );

    psram_len_sel #(.BEAT_W(BEAT_W)) u_len (
        .req_beats (req_beats),
        .is_read   (!req_write),
        .blen      (bcfg.blen),
        .eff_beats (eff_beats)
    );

    psram_wait_norm u_wait (
        .mem_wait (mem_wait),
        .wait_hi  (bcfg.wait_hi),
        .wait_act (wait_act)
    );

    assign beat = (q.st == ST_DATA) && !wait_act;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.st   = ST_ADDR;
                    d.addr = req_addr;
                    d.wr   = req_write || req_cfg;
                    d.cfg  = req_cfg;
                    d.be   = req_cfg ? 2'b00 : req_bmask;
                    d.cnt  = eff_beats;
                    d.lat  = bcfg.lat;
                end
            end
            ST_ADDR: begin
                if (q.cfg)            d.st = ST_IDLE;
                else if (q.lat == '0) d.st = ST_DATA;
                else                  d.st = ST_LAT;
            end
            ST_LAT: begin
                d.lat = q.lat - 1'b1;
                if (q.lat == LAT_W'(1)) d.st = ST_DATA;
            end
            ST_DATA: begin
                if (!wait_act) begin
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == BEAT_W'(1)) d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_clk_en = (q.st != ST_IDLE);
    assign mem_ce_n   = (q.st == ST_IDLE);
    assign mem_lat_n  = (q.st != ST_ADDR);
    assign mem_we_n   = !((q.st == ST_ADDR) && q.wr);
    assign mem_cre    = (q.st == ST_ADDR) && q.cfg;
    assign mem_oe_n   = !((q.st == ST_DATA) && !q.wr);
    assign mem_dq_oe  = (q.st == ST_DATA) && q.wr;
    assign mem_dq_out = wr_data;
    assign mem_addr   = q.addr;
    assign mem_ub_n   = (q.st == ST_IDLE) || !q.be[1];
    assign mem_lb_n   = (q.st == ST_IDLE) || !q.be[0];
    assign rd_valid   = beat && !q.wr;
    assign rd_data    = mem_dq_in;
    assign wr_ready   = beat && q.wr;
endmodule

// File: rtl/psram_burst_ctrl_chk.sv
module psram_burst_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic mem_ce_n,
    input logic mem_lat_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_cre,
    input logic mem_dq_oe,
    input logic wait_act
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && !mem_dq_oe && !mem_cre));

    p_latch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_lat_n |=> mem_lat_n);

    p_latch_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_lat_n |-> !mem_ce_n);

    p_hold_on_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_oe_n || mem_dq_oe) && wait_act) |=> !mem_ce_n);

    p_bus_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    p_release_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && $past(!mem_oe_n || mem_dq_oe)) |-> !$past(wait_act));

    p_cfg_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cre |-> (!mem_we_n && !mem_lat_n && !mem_ce_n));
endmodule

bind psram_burst_ctrl psram_burst_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_ce_n  (mem_ce_n),
    .mem_lat_n (mem_lat_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_cre   (mem_cre),
    .mem_dq_oe (mem_dq_oe),
    .wait_act  (wait_act)
);

// File: tb/psram_burst_ctrl_tb.sv
module psram_burst_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cfg = 1'b0;
    logic [21:0] req_addr = '0;
    logic [4:0]  req_beats = '0;
    logic [1:0]  req_bmask = '0;
    logic [15:0] wr_data = '0, mem_dq_in = '0;
    logic        mem_wait = 1'b1;
    logic        req_ready, wr_ready, rd_valid, mem_clk_en, mem_lat_n, mem_ce_n;
    logic        mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_cre, mem_dq_oe;
    logic [15:0] rd_data, mem_dq_out;
    logic [21:0] mem_addr;

    int  checks = 0, errors = 0;
    bit  finished = 1'b0;
    bit  pol_cur = 1'b0;
    bit  stall_now = 1'b0;

    always #5 clk = ~clk;

    psram_burst_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_cfg(req_cfg), .req_addr(req_addr),
        .req_beats(req_beats), .req_bmask(req_bmask), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_clk_en(mem_clk_en), .mem_addr(mem_addr), .mem_lat_n(mem_lat_n),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_cre(mem_cre),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_wait(mem_wait)
    );

    typedef struct packed {
        logic       wr;
        logic [4:0] beats;
        logic [2:0] lat;
        logic       pol;
        logic [2:0] code;
        logic [4:0] st_at;
        logic [2:0] st_len;
        logic [4:0] exp;
        logic [1:0] mask;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 5'd4,  3'd3, 1'b0, 3'd7, 5'd0,  3'd0, 5'd4,  2'd3},
        '{1'b0, 5'd6,  3'd4, 1'b1, 3'd1, 5'd2,  3'd3, 5'd4,  2'd1},
        '{1'b1, 5'd6,  3'd4, 1'b1, 3'd1, 5'd1,  3'd2, 5'd6,  2'd2},
        '{1'b0, 5'd10, 3'd2, 1'b0, 3'd2, 5'd5,  3'd1, 5'd8,  2'd3},
        '{1'b1, 5'd0,  3'd0, 1'b0, 3'd7, 5'd0,  3'd0, 5'd1,  2'd3},
        '{1'b0, 5'd20, 3'd5, 1'b1, 3'd3, 5'd15, 3'd2, 5'd16, 2'd2},
        '{1'b0, 5'd3,  3'd1, 1'b0, 3'd7, 5'd1,  3'd1, 5'd3,  2'd1}
    };

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_wait();
        mem_wait = pol_cur ? stall_now : ~stall_now;
    endtask

    task automatic cfg_write(input logic [21:0] word);
        @(negedge clk);
        req_valid = 1'b1; req_cfg = 1'b1; req_write = 1'b1; req_addr = word;
        @(posedge clk); #1;
        req_valid = 1'b0; req_cfg = 1'b0; req_write = 1'b0;
        @(negedge clk);
        check_eq("R9 cfg pins cre/we_n/lat_n/ce_n", {mem_cre, mem_we_n, mem_lat_n, mem_ce_n}, 4'b1000);
        check_eq("R9 cfg word on address", mem_addr, word);
        check_eq("R9 cfg byte enables off", {mem_ub_n, mem_lb_n}, 2'b11);
        @(negedge clk);
        check_eq("R9 cfg single cycle", {mem_ce_n, req_ready}, 2'b11);
    endtask

    task automatic run_txn(input bit wr, input logic [4:0] beats, input logic [1:0] mask,
                           input int st_at, input int st_len, input int lat,
                           input int exp, input logic [21:0] addr);
        int cyc = 1, first = 0, nb = 0, stalled = 0, oe_cnt = 0, dq_cnt = 0, end_cyc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_beats = beats; req_bmask = mask;
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (end_cyc == 0 && cyc < 200) begin
            @(negedge clk);
            stall_now = (st_len > 0) && (nb == st_at) && (stalled < st_len);
            drive_wait();
            wr_data   = 16'hC000 + 16'(nb);
            mem_dq_in = 16'h3000 + 16'(nb);
            #1;
            if (cyc == 1) begin
                check_eq("R2 address phase lat_n/ce_n", {mem_lat_n, mem_ce_n}, 2'b00);
                check_eq("R2 address pins", mem_addr, addr);
                check_eq("R2 we_n by direction", mem_we_n, !wr);
            end
            if (mem_ce_n) begin
                end_cyc = cyc;
            end else begin
                if ({mem_ub_n, mem_lb_n} !== ~mask)
                    check_eq("R2 byte enables held", {mem_ub_n, mem_lb_n}, ~mask);
                if (!mem_oe_n) oe_cnt++;
                if (mem_dq_oe) dq_cnt++;
                if (stall_now) stalled++;
                if (rd_valid || wr_ready) begin
                    if (first == 0) first = cyc;
                    if (wr) check_eq("R6 write data on bus", mem_dq_out, 16'hC000 + 16'(nb));
                    else    check_eq("R5 read data delivered", rd_data, 16'h3000 + 16'(nb));
                    nb++;
                end
            end
            cyc++;
        end
        stall_now = 1'b0;
        drive_wait();
        check_eq("R3 first beat cycle", first, 2 + lat);
        check_eq("R7 beat count", nb, exp);
        check_eq("R4 stalls honoured", stalled, st_len);
        check_eq("R8 chip enable release cycle", end_cyc, 2 + lat + exp + st_len);
        check_eq("R5 oe_n low cycles", oe_cnt, wr ? 0 : exp + st_len);
        check_eq("R6 drive enable cycles", dq_cnt, wr ? exp + st_len : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        drive_wait();
        repeat (3) @(negedge clk);
        check_eq("R1 reset ready/clk_en", {req_ready, mem_clk_en}, 2'b10);
        check_eq("R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_lat_n, mem_ub_n, mem_lb_n}, 6'h3F);
        check_eq("R1 reset cre/dq_oe", {mem_cre, mem_dq_oe}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 idle after reset", {req_ready, mem_ce_n, mem_clk_en}, 3'b110);

        // R10: reset settings are latency 3, active-low WAIT, continuous length
        run_txn(1'b0, 5'd2, 2'b11, 0, 0, 3, 2, 22'h01234);
        run_txn(1'b0, 5'd20, 2'b10, 3, 1, 3, 20, 22'h00400);

        for (int i = 0; i < 7; i++) begin
            cfg_write(22'(2'b10) << 18 | 22'(VECS[i].lat) << 11 | 22'(VECS[i].pol) << 10
                      | 22'(VECS[i].code));
            pol_cur = VECS[i].pol;
            drive_wait();
            run_txn(VECS[i].wr, VECS[i].beats, VECS[i].mask, int'(VECS[i].st_at),
                    int'(VECS[i].st_len), int'(VECS[i].lat), int'(VECS[i].exp),
                    22'h2A5F0 + 22'(i * 64));
        end

        // R9: refresh-register select leaves latency 1, active-low WAIT, continuous in force
        cfg_write(22'(2'b00) << 18 | 22'(3'd7) << 11 | 22'(1) << 10 | 22'(3'd1));
        run_txn(1'b0, 5'd6, 2'b01, 2, 1, 1, 6, 22'h3FFFF);

        @(negedge clk);
        check_eq("R1 idle at end", {req_ready, mem_ce_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule